// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory Target

This block is the device side of a two-wire serial memory. The host drives a bus clock and shares one open-drain data line with the block. The block sees the line through a data input and pulls it low through an enable output. A system clock samples both bus lines after a synchroniser. The block finds start and stop conditions and answers only to its own fixed device address. It takes a memory address of two or three bytes, and it holds a byte array whose size is set by a parameter. The array reads as all zeros after reset.

A write sends a device byte with the direction bit clear, then the address bytes, then one or more data bytes. The data bytes go into a page buffer, and the write address wraps inside the current page. A stop then starts an internal write cycle. That cycle lasts a parameter number of system clocks, and the buffered bytes move into the array when it ends. The block ignores the bus for the whole cycle, so a host polls with its device address until the block acknowledges again. A read can start at the current address. A random read first loads the address through a write header and then begins the read with a repeated start. A sequential read continues for as long as the host acknowledges each byte.

Both bus lines are ordinary control pins. No data-stream interface exists at the block's edge, so no back-pressure rules apply.

Top module: `tw_cfgmem_target`

## Requirements
- R1: After reset the data pull output is low (the line is released), and every array byte reads as 0x00.
- R2: A start condition (data falls while the bus clock is high) sends the block back to receiving a device byte from any state, even in the middle of a byte. A stop condition (data rises while the bus clock is high) ends the message.
- R3: The device byte is shifted MSB first. The value 0xA6 (bits 7..1 = 1010011, bit 0 = 0) selects a write and 0xA7 selects a read. On the ninth bus clock the block pulls data low to accept the byte. Any other value is refused with the line released, and the block then ignores the bus until the next start.
- R4: ADDR_BYTES address bytes (2 or 3) follow a write device byte. Each is shifted MSB first and each is acknowledged. The low bits of the combined value, most significant byte first, form the array address.
- R5: Data bytes are shifted LSB first in both directions, and each received data byte is acknowledged. For a read bit of 0 the block pulls the line low; for a 1 it releases the line. The pull changes only while the bus clock is low.
- R6: Each written data byte advances only the low PAGE_BITS address bits, so bytes that run past the end of a page wrap to the start of the same page.
- R7: A stop after at least one data byte starts a write cycle of WRITE_CYCLES system clocks. During that cycle the block acknowledges nothing, its own device byte included. The written data is readable once the cycle has ended.
- R8: The current address is the last byte read or written plus one, over the full array width, and it wraps from the top of the array to 0. A write that ends on the last byte of a page therefore leaves the current address at the first byte of the next page. A read with no address bytes starts at the current address.
- R9: A read continues with the next byte while the host acknowledges. After a refused byte, the host's stop ends the read.
- R10: A stop that follows the address bytes with no data byte starts no write cycle, and the next device byte is acknowledged at once. The loaded address is kept.
- R11: A write header that carries only address bytes, then a repeated start and a read device byte, returns data from the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock from the host |
| sda_i | input | 1 | Level seen on the shared data line |
| sda_pull_o | output | 1 | High to pull the data line low |

## Verification
A wrong bit counter or a wrong state shows up at the pins within one byte time. The acknowledge appears on the wrong bus clock, or is refused, or the line is pulled when a one-bit should leave it released. A wrong address or page-wrap register shows nothing on the bus until the next read. That read returns the wrong byte for the current address or from a wrapped page. So each write is read back with a current-address read and then with a full-page sequential read. A busy timer that ends too early or too late shows as an acknowledge on the first polling attempt, or as a poll that never succeeds.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } tw_state_e;

  localparam logic [6:0] TW_DEV_ID = 7'b1010011;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign scl_q = scl_p[STAGES];
  assign sda_s = sda_p[STAGES-1];
  assign sda_q = sda_p[STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == CW'(CYCLES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: the controller never restarts a cycle that is still running
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: rtl/tw_page_store.sv
module tw_page_store #(
  parameter int MEM_BYTES = 512,
  parameter int PAGE_BITS = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(MEM_BYTES)-1:0] wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         discard,
  input  logic                         commit,
  input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
  output logic [7:0]                   rd_data
);
  localparam int AW       = $clog2(MEM_BYTES);
  localparam int PAGE_LEN = 1 << PAGE_BITS;

  logic [7:0]           mem  [MEM_BYTES];
  logic [7:0]           pbuf [PAGE_LEN];
  logic [PAGE_LEN-1:0]  pvalid;
  logic [AW-PAGE_BITS-1:0] page_base;

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_addr[PAGE_BITS-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid    <= '0;
      page_base <= '0;
    end else if (discard) begin
      pvalid <= '0;
    end else if (commit) begin
      pvalid <= '0;
    end else if (wr_en) begin
      pvalid[wr_addr[PAGE_BITS-1:0]] <= 1'b1;
      page_base <= wr_addr[AW-1:PAGE_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < PAGE_LEN; i++)
        if (pvalid[i]) mem[{page_base, PAGE_BITS'(i)}] <= pbuf[i];
    end
  end

  assign rd_data = mem[rd_addr];

  // R7: a commit only ever follows buffered data
  p_commit_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pvalid != '0));
  // R6: all bytes of one message land in a single page
  p_one_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pvalid != '0) |-> (wr_addr[AW-1:PAGE_BITS] == page_base));
endmodule

// File: rtl/tw_cfgmem_target.sv
module tw_cfgmem_target #(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BITS    = 6,
  parameter int ADDR_BYTES   = 2,
  parameter int WRITE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  import tw_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PB = PAGE_BITS;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, tmr_done;

  tw_state_e state;
  logic [3:0]    bit_cnt;
  logic          ack_ph, rw, pull_q, wr_pending, host_ack;
  logic [7:0]    shreg, rd_byte, rd_data;
  logic [1:0]    abyte_cnt;
  logic [AW-1:0] addr_sh, cur_addr, wr_addr;

  logic byte_done, wr_stb, tmr_go, discard;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall & ~ack_ph & (bit_cnt == 4'd8);
  assign wr_stb    = byte_done & (state == ST_WDATA) & ~busy;
  assign tmr_go    = stop_det & ~busy & wr_pending;
  assign discard   = start_det & ~busy;

  tw_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(tmr_go), .busy(busy), .done(tmr_done)
  );

  tw_page_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BITS(PAGE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .wr_addr(wr_addr),
    .wr_data(shreg), .discard(discard), .commit(tmr_done),
    .rd_addr(cur_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      ack_ph     <= 1'b0;
      rw         <= 1'b0;
      pull_q     <= 1'b0;
      wr_pending <= 1'b0;
      host_ack   <= 1'b0;
      shreg      <= '0;
      rd_byte    <= '0;
      abyte_cnt  <= '0;
      addr_sh    <= '0;
      cur_addr   <= '0;
      wr_addr    <= '0;
    end else if (busy) begin
      state      <= ST_IDLE;
      pull_q     <= 1'b0;
      ack_ph     <= 1'b0;
      wr_pending <= 1'b0;
    end else if (start_det) begin
      state      <= ST_DEV;
      bit_cnt    <= '0;
      ack_ph     <= 1'b0;
      pull_q     <= 1'b0;
      wr_pending <= 1'b0;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      ack_ph     <= 1'b0;
      pull_q     <= 1'b0;
      wr_pending <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && !ack_ph && bit_cnt < 4'd8) begin
            shreg   <= (state == ST_WDATA) ? {sda_s, shreg[7:1]} : {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_done) begin
            if (state == ST_DEV) begin
              if (shreg[7:1] == TW_DEV_ID) begin
                pull_q <= 1'b1;
                ack_ph <= 1'b1;
                rw     <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              pull_q  <= 1'b1;
              ack_ph  <= 1'b1;
              addr_sh <= AW'({addr_sh, shreg});
            end else begin
              pull_q     <= 1'b1;
              ack_ph     <= 1'b1;
              wr_addr    <= {wr_addr[AW-1:PB], wr_addr[PB-1:0] + PB'(1)};
              cur_addr   <= wr_addr + 1'b1;
              wr_pending <= 1'b1;
            end
          end
          if (scl_fall && ack_ph) begin
            ack_ph  <= 1'b0;
            bit_cnt <= '0;
            pull_q  <= 1'b0;
            if (state == ST_DEV) begin
              if (rw) begin
                state   <= ST_RDATA;
                rd_byte <= rd_data;
                pull_q  <= ~rd_data[0];
              end else begin
                state     <= ST_ADDR;
                abyte_cnt <= '0;
              end
            end else if (state == ST_ADDR) begin
              if (abyte_cnt == 2'(ADDR_BYTES - 1)) begin
                state    <= ST_WDATA;
                cur_addr <= addr_sh;
                wr_addr  <= addr_sh;
              end else begin
                abyte_cnt <= abyte_cnt + 1'b1;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              pull_q   <= 1'b0;
              state    <= ST_RACK;
              host_ack <= 1'b0;
              cur_addr <= cur_addr + 1'b1;
            end else begin
              pull_q <= ~rd_byte[bit_cnt[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          if (scl_fall) begin
            if (host_ack) begin
              state   <= ST_RDATA;
              bit_cnt <= '0;
              rd_byte <= rd_data;
              pull_q  <= ~rd_data[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: pull_q <= 1'b0;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  // R7: silent on the bus while the write cycle runs
  p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pull_q);
  // R5: the pull only moves while the bus clock is low
  p_pull_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_s);
  // R2: a start re-arms device byte reception
  p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !busy) |=> (state == ST_DEV && bit_cnt == 4'd0 && !pull_q));
  // R6: a written byte never moves the page bits
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (wr_addr[AW-1:PB] == $past(wr_addr[AW-1:PB])));
endmodule

// File: tb/tw_cfgmem_target_tb.sv
module tw_cfgmem_target_tb;
  localparam int MEM = 512;
  localparam int PB  = 6;
  localparam int AB  = 3;
  localparam int WC  = 400;
  localparam int H   = 8;
  localparam int Q   = 2;
  localparam int NV  = 6;
  // {start address[31:16], byte count[15:8], pattern seed[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_40_11, 32'h0050_40_3C, 32'h00C5_03_A0,
    32'h013E_05_5A, 32'h01C0_0A_F0, 32'h007F_01_99
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic pull;
  logic sda_line;
  assign sda_line = host_sda & ~pull;

  tw_cfgmem_target #(.MEM_BYTES(MEM), .PAGE_BITS(PB), .ADDR_BYTES(AB),
                     .WRITE_CYCLES(WC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(pull)
  );

  logic [7:0] model [MEM];
  int n_chk = 0;
  int n_fail = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(H);
    scl = 1'b1;      tick(H);
    host_sda = 1'b0; tick(H);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(H);
    scl = 1'b1;      tick(H);
    host_sda = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; tick(H);
    scl = 1'b1;   tick(H);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit msb_first, output bit acked);
    for (int i = 0; i < 8; i++) send_bit(msb_first ? b[7-i] : b[i]);
    host_sda = 1'b1; tick(H);
    scl = 1'b1;      tick(H/2);
    acked = (sda_line == 1'b0);
    tick(H/2);
    scl = 1'b0;      tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      host_sda = 1'b1; tick(H);
      scl = 1'b1;      tick(H/2);
      v[i] = sda_line;
      tick(H/2);
      scl = 1'b0;      tick(Q);
    end
    send_bit(give_ack ? 1'b0 : 1'b1);
    host_sda = 1'b1;
  endtask

  task automatic send_addr(input int a, output int nacks);
    bit ak;
    nacks = 0;
    for (int k = AB - 1; k >= 0; k--) begin
      send_byte(8'((a >> (8 * k)) & 255), 1'b1, ak);
      if (!ak) nacks++;
    end
  endtask

  initial begin
    bit ak;
    int nk, a, n, idx, last, polls, base;
    logic [7:0] seed, d;

    for (int i = 0; i < MEM; i++) model[i] = 8'h00;
    tick(4);
    chk("R1 line released in reset", int'(pull), 0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 line released after reset", int'(pull), 0);

    // R3: foreign device byte refused, and ignored until the next start
    bus_start();
    send_byte(8'hA4, 1'b1, ak);
    chk("R3 foreign device byte refused", int'(ak), 0);
    send_byte(8'hA6, 1'b1, ak);
    chk("R3 ignored until next start", int'(ak), 0);
    bus_stop();

    // R10: address-only header, stop, no write cycle
    bus_start();
    send_byte(8'hA6, 1'b1, ak);
    chk("R3 write device byte acked", int'(ak), 1);
    send_addr(32'h10, nk);
    chk("R4 all address bytes acked", nk, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA6, 1'b1, ak);
    chk("R10 no write cycle after address-only stop", int'(ak), 1);
    bus_start();
    send_byte(8'hA7, 1'b1, ak);
    chk("R3 read device byte acked", int'(ak), 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R1 R10 blank byte at kept address", int'(d), 0);

    // R2: start in the middle of a byte re-arms the device byte
    model[32'h11] = 8'h00;
    bus_start();
    send_byte(8'hA6, 1'b1, ak);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(8'hA7, 1'b1, ak);
    chk("R2 device byte after mid-byte start", int'(ak), 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R2 R8 read at next address", int'(d), int'(model[32'h11]));

    for (int v = 0; v < NV; v++) begin
      a    = int'(VEC[v][31:16]);
      n    = int'(VEC[v][15:8]);
      seed = VEC[v][7:0];
      last = 0;
      bus_start();
      send_byte(8'hA6, 1'b1, ak);
      chk("R3 write device byte acked", int'(ak), 1);
      send_addr(a, nk);
      chk("R4 address bytes acked", nk, 0);
      for (int i = 0; i < n; i++) begin
        d   = 8'(int'(seed) + i * 7);
        idx = (a & ~63) | ((a + i) & 63);
        model[idx] = d;
        last = idx;
        send_byte(d, 1'b0, ak);
        chk("R5 data byte acked", int'(ak), 1);
      end
      bus_stop();

      bus_start();
      send_byte(8'hA6, 1'b1, ak);
      chk("R7 device byte refused during write cycle", int'(ak), 0);
      polls = 1;
      while (!ak && polls < 20) begin
        bus_start();
        send_byte(8'hA6, 1'b1, ak);
        polls++;
      end
      chk("R7 write cycle ends", int'(ak), 1);

      bus_start();
      send_byte(8'hA7, 1'b1, ak);
      recv_byte(1'b0, d);
      bus_stop();
      chk("R8 current address after write", int'(d), int'(model[(last + 1) % MEM]));

      base = a & ~63;
      bus_start();
      send_byte(8'hA6, 1'b1, ak);
      send_addr(base, nk);
      bus_start();
      send_byte(8'hA7, 1'b1, ak);
      chk("R11 read after address-only header", int'(ak), 1);
      for (int j = 0; j < 64; j++) begin
        recv_byte(j != 63, d);
        chk("R5 R6 R9 page readback", int'(d), int'(model[base + j]));
      end
      bus_stop();
    end

    // R8: sequential read wraps from the top of the array to zero
    bus_start();
    send_byte(8'hA6, 1'b1, ak);
    send_addr(MEM - 1, nk);
    bus_start();
    send_byte(8'hA7, 1'b1, ak);
    recv_byte(1'b1, d);
    chk("R8 top byte", int'(d), int'(model[MEM - 1]));
    recv_byte(1'b0, d);
    bus_stop();
    chk("R8 R9 wrap to address zero", int'(d), int'(model[0]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule